// File: doc/BRIEF.md
# Serial speech ROM command controller

This block is the control side of a serially addressed speech-data memory. A host talks to it over a slow pin protocol: a two-bit mode code, a four-bit nybble bus, a host clock, a gate that masks the host clock, and a chip select. The block runs on a fast system clock. It samples the host clock and acts once on each qualifying falling edge. A command is accepted only when one of the mode bits has risen since the previous qualifying edge. The meaning of the command depends on the one accepted before it.

The host builds a byte address one nybble at a time. It then streams ROM contents back, either one bit per read command or one nybble per read command, chosen by a parameter. A jump command fetches two bytes at the current address and replaces the low ROM address bits with them. This gives indirect branching through pointer tables. The ROM sits behind a synchronous byte port: the block drives an address, and the byte comes back in the same cycle.

Top module: `spchrom_ctrl`

## Requirements
- R1: After synchronous reset, `dq_o` is 0 and `rom_addr` is 0.
- R2: The block acts only on a system-clock cycle that sees `host_clk` fall from 1 to 0 while `host_clk_mask` is 0 and `sel_i` is 1. A fall while masked or deselected changes no output and consumes no command.
- R3: `mode_i` codes are 0 idle, 1 read, 2 load nybble, 3 jump. A command is taken only when a `mode_i` bit is 1 now and was 0 at the previous qualifying edge. Holding `mode_i` steady across edges issues nothing.
- R4: A load directly after a read writes `nyb_i` into address bits [3:0] and clears the step counter. Each load directly after a load writes nybble position step+1 (bits [4p+3:4p]) while that position exists. The step counter then increments modulo 8. Loads beyond the last nybble change no address bit.
- R5: A read directly after a load is a dummy. It clears the step counter and leaves `dq_o` unchanged.
- R6: In one-bit mode, a read at step 0 fetches the ROM byte at the current address. Later steps rotate that byte right. Bit 0 of the register appears on `dq_o[3]`, so byte bits stream LSB first. `dq_o[2:0]` are 0.
- R7: In nybble mode, an even step outputs register bits [3:0] and an odd step outputs bits [6:3] of the once-rotated register, which are the fetched byte's bits [7:4]. With the reversal option, the fetched byte is bit-reversed before it enters the register.
- R8: The step counter of a read wraps modulo 8 (one-bit mode) or modulo 2 (nybble mode). Each wrap to 0 increments the byte address.
- R9: A jump directly after a load, or after a read that left the step at 0, takes effect as follows. It clears the step. It reads byte B at address A and byte C at A+1. It sets the low ROM address bits to C:B (C high). `rom_addr` shows the result within two system cycles.
- R10: A jump in any other situation changes nothing, yet still counts as the previous command. A load right after it changes no address bit, and a read after that load is a dummy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_clk | input | 1 | Host protocol clock, acted on at its falling edge |
| host_clk_mask | input | 1 | When 1, host clock edges are ignored |
| sel_i | input | 1 | Chip select, active high |
| mode_i | input | 2 | Command code from the host |
| nyb_i | input | 4 | Address nybble from the host |
| rom_addr | output | ROM_AW | Byte address to the ROM port |
| rom_data | input | 8 | Byte returned by the ROM port in the same cycle |
| dq_o | output | 4 | Serial data to the host: bit on [3] or a full nybble |

## Verification
The hardest states to reach involve the jump. Its effect depends on the previous command and on how far the step counter has advanced. These states also differ between the one-bit and nybble variants. The bench drives both variants side by side from one host sequence and counts reads to land exactly on a finished byte (eight reads satisfy both moduli) or mid-byte (three reads). It then follows an ignored jump with a load and a read. This exposes that the ignored jump was still recorded as the previous command and that the load turned the following read into a dummy.

// File: rtl/spchrom_pkg.sv
package spchrom_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE = 2'd0,
      CMD_READ = 2'd1,
      CMD_LOAD = 2'd2,
      CMD_JUMP = 2'd3
   } vcmd_t;
endpackage

// File: rtl/spchrom_strobe.sv
module spchrom_strobe
   import spchrom_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       host_clk,
   input  logic       host_clk_mask,
   input  logic       sel_i,
   input  logic [1:0] mode_i,
   output logic       strobe,
   output logic       cmd_vld,
   output vcmd_t      cmd
);
   logic       clk_q;
   logic [1:0] mode_q;

   // qualified falling edge of the host clock
   assign strobe  = clk_q & ~host_clk & ~host_clk_mask & sel_i;
   // a command needs a mode bit that rose since the last qualified edge
   assign cmd_vld = strobe & (|(mode_i & ~mode_q));
   assign cmd     = vcmd_t'(mode_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         clk_q  <= 1'b0;
         mode_q <= 2'b00;
      end else begin
         clk_q <= host_clk;
         if (strobe) mode_q <= mode_i;
      end
   end

   // R3: an accepted command always carries a nonzero code
   a_r3_no_idle_cmd: assert property (@(posedge clk) disable iff (rst)
      cmd_vld |-> (mode_i != 2'b00));
endmodule

// File: rtl/spchrom_shift.sv
module spchrom_shift #(
   parameter int NIB_MODE = 0,
   parameter int BIT_REV  = 0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  logic       rot,
   input  logic       odd,
   input  logic [7:0] din,
   output logic [3:0] dq_o
);
   logic [7:0] din_o;
   logic [7:0] sa, sa_nx;
   logic [3:0] nib_v, bit_v, dq_nx;

   if (BIT_REV != 0) begin : g_rev
      for (genvar i = 0; i < 8; i++) begin : g_bit
         assign din_o[i] = din[7-i];
      end
   end else begin : g_fwd
      assign din_o = din;
   end

   assign sa_nx = load ? din_o : {sa[0], sa[7:1]};
   assign nib_v = odd ? sa_nx[6:3] : sa_nx[3:0];
   assign bit_v = {sa_nx[0], 3'b000};
   assign dq_nx = (NIB_MODE != 0) ? nib_v : bit_v;

   always_ff @(posedge clk) begin
      if (rst) begin
         sa   <= 8'h00;
         dq_o <= 4'h0;
      end else if (load | rot) begin
         sa   <= sa_nx;
         dq_o <= dq_nx;
      end
   end

   // R6: fetch and rotate are never requested together
   a_r6_one_op: assert property (@(posedge clk) disable iff (rst)
      !(load && rot));
endmodule

// File: rtl/spchrom_ctrl.sv
module spchrom_ctrl
   import spchrom_pkg::*;
#(
   parameter int NIBS     = 5,
   parameter int ROM_AW   = 14,
   parameter int NIB_MODE = 0,
   parameter int BIT_REV  = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_clk,
   input  logic              host_clk_mask,
   input  logic              sel_i,
   input  logic [1:0]        mode_i,
   input  logic [3:0]        nyb_i,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic [7:0]        rom_data,
   output logic [3:0]        dq_o
);
   localparam int         ADDR_W   = 4 * NIBS;
   localparam logic [2:0] STEP_MAX = (NIB_MODE != 0) ? 3'd1 : 3'd7;

   if (NIBS < 4 || NIBS > 8) begin : g_bad_nibs
      $error("spchrom_ctrl: NIBS must be 4..8");
   end
   if (ROM_AW < 8 || ROM_AW > 16 || ROM_AW > ADDR_W) begin : g_bad_aw
      $error("spchrom_ctrl: ROM_AW must be 8..16 and fit the address");
   end

   logic              strobe, cmd_vld;
   vcmd_t             cmd, prev_cmd;
   logic [ADDR_W-1:0] addr;
   logic [2:0]        step, step_nx;
   logic              rb_pend;
   logic [7:0]        lo_byte;
   logic              read_go, jump_ok;

   spchrom_strobe u_strobe (
      .clk           (clk),
      .rst           (rst),
      .host_clk      (host_clk),
      .host_clk_mask (host_clk_mask),
      .sel_i         (sel_i),
      .mode_i        (mode_i),
      .strobe        (strobe),
      .cmd_vld       (cmd_vld),
      .cmd           (cmd)
   );

   assign read_go  = cmd_vld && (cmd == CMD_READ) && (prev_cmd != CMD_LOAD);
   assign step_nx  = (step + 3'd1) & STEP_MAX;
   assign jump_ok  = (prev_cmd == CMD_LOAD) ||
                     ((prev_cmd == CMD_READ) && (step == 3'd0));
   assign rom_addr = addr[ROM_AW-1:0];

   spchrom_shift #(.NIB_MODE(NIB_MODE), .BIT_REV(BIT_REV)) u_shift (
      .clk  (clk),
      .rst  (rst),
      .load (read_go && (step == 3'd0)),
      .rot  (read_go && (step != 3'd0)),
      .odd  (step[0]),
      .din  (rom_data),
      .dq_o (dq_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         addr     <= '0;
         step     <= 3'd0;
         prev_cmd <= CMD_IDLE;
         rb_pend  <= 1'b0;
         lo_byte  <= 8'h00;
      end else if (rb_pend) begin
         // second phase of a jump: high byte is on the port now
         addr[ROM_AW-1:0] <= ROM_AW'({rom_data, lo_byte});
         rb_pend          <= 1'b0;
      end else if (cmd_vld) begin
         prev_cmd <= cmd;
         case (cmd)
            CMD_READ: begin
               if (prev_cmd == CMD_LOAD) begin
                  step <= 3'd0;
               end else begin
                  step <= step_nx;
                  if (step_nx == 3'd0) addr <= addr + 1'b1;
               end
            end
            CMD_LOAD: begin
               if (prev_cmd == CMD_READ) begin
                  addr[3:0] <= nyb_i;
                  step      <= 3'd0;
               end else if (prev_cmd == CMD_LOAD) begin
                  for (int p = 1; p < NIBS; p++) begin
                     if (step == 3'(p - 1)) addr[4*p +: 4] <= nyb_i;
                  end
                  step <= step + 3'd1;
               end
            end
            CMD_JUMP: begin
               if (jump_ok) begin
                  step    <= 3'd0;
                  lo_byte <= rom_data;
                  addr    <= addr + 1'b1;
                  rb_pend <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // R2: the data pins move only on a qualified host clock edge
   a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(dq_o));

   // R5: a read right after a load leaves data alone and clears the step
   a_r5_dummy: assert property (@(posedge clk) disable iff (rst)
      (cmd_vld && cmd == CMD_READ && prev_cmd == CMD_LOAD) |=>
      (step == 3'd0 && $stable(dq_o)));

   // R8: the last step of a byte advances the address by one
   a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
      (read_go && step == STEP_MAX) |=> (addr == $past(addr) + 1'b1));

   // R9: the jump's second phase lasts one cycle and never meets a command
   a_r9_phase: assert property (@(posedge clk) disable iff (rst)
      rb_pend |-> (!cmd_vld ##1 !rb_pend));

   // R10: a jump that is not allowed leaves the address untouched
   a_r10_skip: assert property (@(posedge clk) disable iff (rst)
      (cmd_vld && cmd == CMD_JUMP && !jump_ok) |=> ($stable(addr) && !rb_pend));
endmodule

// File: tb/spchrom_ctrl_tb.sv
`timescale 1ns/1ps
module spchrom_ctrl_tb;
   localparam int AW = 14;
   localparam int AMASK = (1 << AW) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic host_clk = 1'b0, host_clk_mask = 1'b0, sel_i = 1'b1;
   logic [1:0] mode_i = 2'd0;
   logic [3:0] nyb_i = 4'd0;
   logic [AW-1:0] ra1, ran;
   logic [7:0] rd1, rdn;
   logic [3:0] dq1, dqn;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   function automatic logic [7:0] rom_f(input int a);
      int m;
      m = a & AMASK;
      return 8'(((m * 73) + (m >>> 5) + 19) ^ 8'hA6);
   endfunction

   function automatic logic [7:0] rev8(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

   function automatic int exp_bit(input int a, input int k);
      logic [7:0] b;
      b = rom_f(a + k / 8);
      return {28'd0, b[k % 8], 3'b000};
   endfunction

   function automatic int exp_nib(input int a, input int k);
      logic [7:0] r;
      r = rev8(rom_f(a + k / 2));
      return (k % 2 == 1) ? int'(r[7:4]) : int'(r[3:0]);
   endfunction

   function automatic int jump_tgt(input int a);
      return ((rom_f(a + 1) << 8) | rom_f(a)) & AMASK;
   endfunction

   always_comb rd1 = rom_f(int'(ra1));
   always_comb rdn = rom_f(int'(ran));

   spchrom_ctrl #(.NIB_MODE(0), .BIT_REV(0)) u_dut (
      .clk(clk), .rst(rst), .host_clk(host_clk), .host_clk_mask(host_clk_mask),
      .sel_i(sel_i), .mode_i(mode_i), .nyb_i(nyb_i),
      .rom_addr(ra1), .rom_data(rd1), .dq_o(dq1));

   spchrom_ctrl #(.NIB_MODE(1), .BIT_REV(1)) u_dut_nib (
      .clk(clk), .rst(rst), .host_clk(host_clk), .host_clk_mask(host_clk_mask),
      .sel_i(sel_i), .mode_i(mode_i), .nyb_i(nyb_i),
      .rom_addr(ran), .rom_data(rdn), .dq_o(dqn));

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic pulse(input logic [1:0] m, input logic [3:0] n,
                        input logic msk, input logic sl);
      @(negedge clk);
      mode_i = m; nyb_i = n; host_clk_mask = msk; sel_i = sl; host_clk = 1'b1;
      repeat (2) @(negedge clk);
      host_clk = 1'b0;
      repeat (3) @(negedge clk);
      host_clk_mask = 1'b0; sel_i = 1'b1;
   endtask

   task automatic issue(input logic [1:0] m, input logic [3:0] n);
      pulse(2'd0, n, 1'b0, 1'b1);
      pulse(m, n, 1'b0, 1'b1);
   endtask

   task automatic load(input logic [19:0] a, input bit extra);
      issue(2'd1, 4'd0);
      for (int i = 0; i < 5; i++) issue(2'd2, a[4*i +: 4]);
      if (extra) issue(2'd2, 4'hF);
   endtask

   task automatic reads(input int a, input int k0, input int n, input string tg1,
                        input string tgn);
      for (int k = k0; k < k0 + n; k++) begin
         issue(2'd1, 4'd0);
         chk(tg1, int'(dq1), exp_bit(a, k));
         chk(tgn, int'(dqn), exp_nib(a, k));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int sweep[4];
      int a, d1, dn;
      sweep = '{32'h0123, 32'h1FFE, 32'h3FFF, 32'h2A5C};
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk("R1 dq", int'(dq1), 0);
      chk("R1 dq nib", int'(dqn), 0);
      chk("R1 addr", int'(ra1), 0);
      chk("R1 addr nib", int'(ran), 0);

      // sweep of start addresses, both output variants
      foreach (sweep[i]) begin
         a = sweep[i];
         load(20'(a), 1'b0);
         chk("R4 load", int'(ra1), a);
         chk("R4 load nib", int'(ran), a);
         d1 = int'(dq1); dn = int'(dqn);
         issue(2'd1, 4'd0);
         chk("R5 dummy", int'(dq1), d1);
         chk("R5 dummy nib", int'(dqn), dn);
         reads(a, 0, 16, "R6 bit", "R7 nib");
         chk("R8 wrap", int'(ra1), (a + 2) & AMASK);
         chk("R8 wrap nib", int'(ran), (a + 8) & AMASK);
      end

      // R4: a sixth load is beyond the last nybble
      load(20'h00ABC, 1'b1);
      chk("R4 extra", int'(ra1), 32'h0ABC);
      chk("R4 extra nib", int'(ran), 32'h0ABC);

      // R2 / R3: gating and held mode code
      a = 32'h0ABC;
      issue(2'd1, 4'd0);
      reads(a, 0, 2, "R6 pre", "R7 pre");
      d1 = int'(dq1); dn = int'(dqn);
      pulse(2'd0, 4'd0, 1'b0, 1'b1);
      pulse(2'd1, 4'd0, 1'b1, 1'b1);
      chk("R2 masked", int'(dq1), d1);
      chk("R2 masked nib", int'(dqn), dn);
      pulse(2'd1, 4'd0, 1'b0, 1'b0);
      chk("R2 deselected", int'(dq1), d1);
      chk("R2 deselected addr", int'(ra1), a);
      pulse(2'd1, 4'd0, 1'b0, 1'b1);
      chk("R2 after gate", int'(dq1), exp_bit(a, 2));
      chk("R2 after gate nib", int'(dqn), exp_nib(a, 2));
      pulse(2'd1, 4'd0, 1'b0, 1'b1);
      chk("R3 held", int'(dq1), exp_bit(a, 2));
      chk("R3 held nib", int'(dqn), exp_nib(a, 2));
      reads(a, 3, 1, "R3 next", "R3 next nib");

      // R9: jump directly after loads
      a = 32'h1234;
      load(20'(a), 1'b0);
      issue(2'd3, 4'd0);
      chk("R9 after load", int'(ra1), jump_tgt(a));
      chk("R9 after load nib", int'(ran), jump_tgt(a));
      reads(jump_tgt(a), 0, 8, "R9 stream", "R9 stream nib");

      // R9: jump after a finished byte (8 reads suit both moduli)
      a = 32'h0777;
      load(20'(a), 1'b0);
      issue(2'd1, 4'd0);
      reads(a, 0, 8, "R6 run", "R7 run");
      issue(2'd3, 4'd0);
      chk("R9 after byte", int'(ra1), jump_tgt(a + 1));
      chk("R9 after byte nib", int'(ran), jump_tgt(a + 4));

      // R10: jump mid-byte is ignored but remembered
      a = 32'h0555;
      load(20'(a), 1'b0);
      issue(2'd1, 4'd0);
      reads(a, 0, 3, "R6 mid", "R7 mid");
      issue(2'd3, 4'd0);
      chk("R10 jump ignored", int'(ra1), a);
      chk("R10 jump ignored nib", int'(ran), a + 1);
      issue(2'd2, 4'hF);
      chk("R10 load ignored", int'(ra1), a);
      chk("R10 load ignored nib", int'(ran), a + 1);
      d1 = int'(dq1); dn = int'(dqn);
      issue(2'd1, 4'd0);
      chk("R10 dummy", int'(dq1), d1);
      chk("R10 dummy nib", int'(dqn), dn);
      issue(2'd1, 4'd0);
      chk("R10 restart", int'(dq1), exp_bit(a, 0));
      chk("R10 restart nib", int'(dqn), exp_nib(a, 2));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule